// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one integer by another over many clock cycles using the restoring method. It holds the divisor in a register that never moves. It keeps a single double-width working register that carries the partial remainder in its upper half and the dividend in its lower half. Each cycle the block compares the upper half against the divisor with one single-width subtractor. The compare either keeps the difference or keeps the old value, and the working register then moves left by one place. The new quotient bit enters at the bottom of that same register. By the end, the lower half holds the quotient. The upper half holds twice the remainder, so one right shift corrects it.

A caller gives a one-cycle `start` pulse while the block is idle, along with the operands and a signed/unsigned select. `busy` stays high while the division runs. A one-cycle `done` pulse marks the moment the result registers are updated. In signed mode the block divides the operand magnitudes and then fixes the signs of the results. A zero divisor skips the iterations, raises a flag and returns fixed values.

Top module: `restoringDivider`

## Requirements
- R1: When `start` is high and `busy` is low, the block accepts the request at that clock edge, and `busy` is high from the next cycle until `done` rises. While `done` is high, `busy` is low.
- R2: With a nonzero divisor, `done` is a single-cycle pulse that rises on the 33rd clock edge after the accepting edge (WIDTH+1 edges). With a zero divisor it rises on the 1st edge after the accepting edge.
- R3: In unsigned mode (`signedMode`=0), `quotientLo` = floor(dividend/divisor) and `remainderHi` = dividend mod divisor, for the full 32-bit operand range, including divisors with the top bit set.
- R4: In signed mode (`signedMode`=1), operands are two's complement. The quotient is the truncated magnitude quotient, negated when the operand signs differ. The remainder has the magnitude remainder and the sign of the dividend.
- R5: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R6: A zero divisor sets `divByZero`=1, `quotientLo`=0xFFFFFFFF and `remainderHi` equal to the raw dividend, in either mode. A nonzero divisor leaves `divByZero`=0.
- R7: A `start` pulse while `busy` is high is ignored. The running division completes with its own result, and no extra `done` pulse appears.
- R8: `quotientLo`, `remainderHi` and `divByZero` change only on the edge that raises `done`, and hold their values afterwards.
- R9: After reset, `busy`, `done`, `divByZero`, `quotientLo` and `remainderHi` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse, results updated |
| divByZero | output | 1 | The last result came from a zero divisor |
| quotientLo | output | 32 | Quotient of the last division |
| remainderHi | output | 32 | Remainder of the last division |

## Verification
The bench builds the block with its default WIDTH of 32. This makes the hard operands reachable: divisors at or above 2^31, where the shifted partial remainder spills past the top of the upper half, and the signed case of the most negative value divided by minus one. A scoreboard predicts every result from the arithmetic definitions. It also checks that each `done` arrives after the exact number of cycles and that stray `start` pulses during a run leave no trace.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes issued by the sequencer to the datapath each cycle
  typedef struct packed {
    logic load;    // capture operands, first left shift
    logic step;    // one trial subtraction plus shift
    logic finish;  // correct remainder, fix signs, write outputs
  } divStrobe_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divisorZero,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;

  state_t        state;
  logic [CW-1:0] count;

  always_comb begin
    strobe.load   = (state == S_IDLE) && start;
    strobe.step   = (state == S_RUN);
    strobe.finish = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            count <= '0;
            state <= divisorZero ? S_FIX : S_RUN;
          end
        end
        S_RUN: begin
          count <= count + 1'b1;
          if (count == LAST) state <= S_FIX;
        end
        S_FIX: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: done lasts exactly one cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: an accepted start makes the block busy on the next cycle
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R7: a start while iterating does not disturb the iteration count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && count != LAST && start) |=> (state == S_RUN && count == $past(count) + 1'b1));
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divisorZero,
  output logic             divByZero,
  output logic [WIDTH-1:0] quotientLo,
  output logic [WIDTH-1:0] remainderHi
);
  localparam int W2 = 2 * WIDTH;

  logic [W2-1:0]    work;      // {partial remainder, dividend/quotient}
  logic             spill;     // bit shifted out above the upper half
  logic [WIDTH-1:0] divReg;
  logic [WIDTH-1:0] rawDividend;
  logic             negQuot, negRem, zeroSeen;

  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH+1:0] trial;
  logic             trialNeg;
  logic [WIDTH-1:0] qMag, rMag;

  assign divisorZero = (divisor == '0);
  assign magA = (signedMode && dividend[WIDTH-1]) ? -dividend : dividend;
  assign magB = (signedMode && divisor[WIDTH-1])  ? -divisor  : divisor;

  // Single-width subtract on the upper half, widened by the spill bit
  assign trial    = {1'b0, spill, work[W2-1:WIDTH]} - {2'b00, divReg};
  assign trialNeg = trial[WIDTH+1];

  assign qMag = work[WIDTH-1:0];
  assign rMag = {spill, work[W2-1:WIDTH+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work        <= '0;
      spill       <= 1'b0;
      divReg      <= '0;
      rawDividend <= '0;
      negQuot     <= 1'b0;
      negRem      <= 1'b0;
      zeroSeen    <= 1'b0;
      divByZero   <= 1'b0;
      quotientLo  <= '0;
      remainderHi <= '0;
    end else begin
      if (strobe.load) begin
        work        <= {{(WIDTH-1){1'b0}}, magA, 1'b0};
        spill       <= 1'b0;
        divReg      <= magB;
        rawDividend <= dividend;
        negQuot     <= signedMode && (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
        negRem      <= signedMode && dividend[WIDTH-1];
        zeroSeen    <= divisorZero;
      end
      if (strobe.step) begin
        if (trialNeg) begin
          spill <= work[W2-1];
          work  <= {work[W2-2:0], 1'b0};
        end else begin
          spill <= trial[WIDTH-1];
          work  <= {trial[WIDTH-2:0], work[WIDTH-1:0], 1'b1};
        end
      end
      if (strobe.finish) begin
        divByZero <= zeroSeen;
        if (zeroSeen) begin
          quotientLo  <= '1;
          remainderHi <= rawDividend;
        end else begin
          quotientLo  <= negQuot ? -qMag : qMag;
          remainderHi <= negRem  ? -rMag : rMag;
        end
      end
    end
  end

  // R3: before each trial the shifted partial remainder is below twice the divisor
  a_r3_partial_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> ({1'b0, spill, work[W2-1:WIDTH]} < {1'b0, divReg, 1'b0}));

  // R6: zero divisor yields all-ones quotient and the flag
  a_r6_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && zeroSeen) |=> (divByZero && quotientLo == '1 && remainderHi == $past(rawDividend)));

  // R8: results hold except on the finishing edge
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> ($stable(quotientLo) && $stable(remainderHi) && $stable(divByZero)));
endmodule

// File: rtl/restoringDivider.sv
module restoringDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             divByZero,
  output logic [WIDTH-1:0] quotientLo,
  output logic [WIDTH-1:0] remainderHi
);
  divStrobe_t strobe;
  logic       divisorZero;

  divCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .strobe(strobe), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .divisorZero(divisorZero),
    .divByZero(divByZero), .quotientLo(quotientLo), .remainderHi(remainderHi)
  );

  // R1: the done cycle is never a busy cycle
  a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/sim_restoringDivider.sv
module sim_restoringDivider;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           lat;
    int           issued;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] quotientLo, remainderHi;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  expItem_t sb[$];
  expItem_t lastExp;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  restoringDivider #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .divByZero(divByZero), .quotientLo(quotientLo), .remainderHi(remainderHi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic expItem_t predict(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic sgn, input string tag);
    expItem_t e;
    logic [W-1:0] ma, mb, mq, mr;
    e.tag = tag;
    e.issued = 0;
    if (b == '0) begin
      e.q = '1; e.r = a; e.dz = 1'b1; e.lat = 2;
    end else begin
      ma = (sgn && a[W-1]) ? -a : a;
      mb = (sgn && b[W-1]) ? -b : b;
      mq = ma / mb;
      mr = ma % mb;
      e.q = (sgn && (a[W-1] != b[W-1])) ? -mq : mq;
      e.r = (sgn && a[W-1]) ? -mr : mr;
      e.dz = 1'b0;
      e.lat = W + 2;
    end
    return e;
  endfunction

  // Monitor: pop and compare on every done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = sb.pop_front();
        check(quotientLo == e.q, e.tag, "quotient", quotientLo, e.q);
        check(remainderHi == e.r, e.tag, "remainder", remainderHi, e.r);
        check(divByZero == e.dz, "R6", "divByZero flag", {{(W-1){1'b0}}, divByZero}, {{(W-1){1'b0}}, e.dz});
        check((cyc - e.issued) == e.lat, "R2", "done latency", W'(cyc - e.issued), W'(e.lat));
        check(!busy, "R1", "busy during done", {{(W-1){1'b0}}, busy}, '0);
      end
    end
  end

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                       input string tag, input bit interfere);
    expItem_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = predict(a, b, sgn, tag);
    e.issued = cyc;
    start = 1'b1; signedMode = sgn; dividend = a; divisor = b;
    sb.push_back(e);
    lastExp = e;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R1", "busy after accept", {{(W-1){1'b0}}, busy}, 32'd1);
    if (interfere) begin
      repeat (5) @(negedge clk);
      start = 1'b1; signedMode = ~sgn; dividend = 32'h0000_0003; divisor = 32'h0000_0000;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R7", "still busy after ignored start", {{(W-1){1'b0}}, busy}, 32'd1);
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(quotientLo == lastExp.q, "R8", "quotient held", quotientLo, lastExp.q);
    check(remainderHi == lastExp.r, "R8", "remainder held", remainderHi, lastExp.r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (4) @(negedge clk);
    check(!busy, "R9", "busy after reset", {{(W-1){1'b0}}, busy}, '0);
    check(!done, "R9", "done after reset", {{(W-1){1'b0}}, done}, '0);
    check(!divByZero, "R9", "flag after reset", {{(W-1){1'b0}}, divByZero}, '0);
    check(quotientLo == '0, "R9", "quotient after reset", quotientLo, '0);
    check(remainderHi == '0, "R9", "remainder after reset", remainderHi, '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOp(32'd100, 32'd7, 1'b0, "R3", 1'b0);
    runOp(32'd5, 32'd9, 1'b0, "R3", 1'b0);
    runOp(32'hFFFF_FFFF, 32'd1, 1'b0, "R3", 1'b0);
    runOp(32'hFFFF_FFFF, 32'h8000_0000, 1'b0, "R3", 1'b0);
    runOp(32'h8000_0001, 32'hFFFF_FFFF, 1'b0, "R3", 1'b0);
    runOp(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R3", 1'b0);
    runOp(-32'sd7, 32'd2, 1'b1, "R4", 1'b0);
    runOp(32'd7, -32'sd2, 1'b1, "R4", 1'b0);
    runOp(-32'sd7, -32'sd2, 1'b1, "R4", 1'b0);
    runOp(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R5", 1'b0);
    runOp(32'd1234, 32'd0, 1'b0, "R6", 1'b0);
    runOp(-32'sd5, 32'd0, 1'b1, "R6", 1'b0);
    runOp(32'd1000, 32'd33, 1'b0, "R7", 1'b1);
    runOp(-32'sd1000, 32'd33, 1'b1, "R7", 1'b1);

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr * 32'd2654435761;
      b = (lfsr >> (i % 24)) | 32'd1;
      runOp(a, b, i[0], i[0] ? "R4" : "R3", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule